// File: doc/BRIEF.md
# Bit-plane median impulse denoiser

This block removes impulse (salt and pepper) noise from colour pixels. Each cycle it can accept one full filter window of `N` pixels, where `N` is odd. Every pixel carries `CH` channels of `W` unsigned bits, and one pixel position is the window centre. The block treats each channel separately. It never sorts the pixel values with comparators. Instead it counts, for every bit position, how many window pixels have that bit set. From those counts it forms an ascending "bitwise sorted" vector `T(1..N)`: bit `b` of `T(i)` is 1 exactly when `i > N - c_b`, where `c_b` is the ones count of plane `b`. Each bit plane is computed with no interaction with the others.

An outlier estimator `g = 3*s - T(1) - T(N)` is formed from the centre value `s` and the two extreme sorted entries. If `g` reaches the upper rank entry `T(N-t)`, or falls to the lower rank entry `T(1+t)`, the centre is taken as an impulse and is replaced by the bitwise median `T((N+1)/2)`. Otherwise the centre value passes through unchanged. The threshold `t` comes in with each window.

Line buffering that assembles windows from a raster stream lies outside the block. Windows are delivered already assembled.

Top module: `bitplane_median_denoiser`

## Requirements
- R1: A window accepted with `in_valid` high produces `out_valid` high exactly two clock cycles later. A cycle with `in_valid` low produces `out_valid` low two cycles later.
- R2: For each channel, sorted entry `T(i)` has bit `b` set exactly when `i > N - c_b`. The median is `T((N+1)/2)`. Any output bit is therefore set when it is set in every window pixel, and clear when it is clear in every window pixel. A window of identical pixels returns that pixel.
- R3: The estimator `g = 3*s - T(1) - T(N)` is evaluated in signed arithmetic wide enough that negative results and results above `2^W - 1` compare correctly.
- R4: When `g >= T(N-t)` or `g <= T(1+t)`, the channel output is `T((N+1)/2)`.
- R5: When neither comparison of R4 holds, the channel output equals the centre pixel's channel value.
- R6: A threshold above `(N-1)/4 - 1` behaves exactly as the threshold `(N-1)/4 - 1`.
- R7: While `rst_n` is low at a clock edge, `out_valid` and `out_px` are cleared to zero.
- R8: Channels are filtered independently. Window pixel `p`, channel `c` occupies `in_win[(p*CH + c)*W +: W]`, and channel `c` of the result occupies `out_px[c*W +: W]`. The centre is pixel index `CTR` (default 4).
- R9: While `out_valid` is low, `out_px` keeps the last value it presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Window on `in_win` is valid this cycle |
| in_win | input | N*CH*W | Flat window, pixel-major, channel-minor |
| in_thresh | input | TW | Rank threshold t, clamped to (N-1)/4-1 |
| out_valid | output | 1 | Filtered pixel valid |
| out_px | output | CH*W | Filtered pixel, channel c at bits c*W upward |

## Verification
A corrupted ones count in one bit plane misplaces that bit in the median and in both extreme entries. It also moves the estimator, so the error shows on `out_px` two cycles after the affected window, both as a wrong median bit and as a wrong replace-or-keep choice. A fault in the estimator width or comparison flips the keep decision only for windows near the rank bounds, so windows with a saturated centre, a dark centre and a smooth gradient centre are all driven. A misaligned valid or enable pipeline shows as an output one cycle early or late, or as a held value that changes while `out_valid` is low.

// File: rtl/bpm_pkg.sv
// Shared definitions for the bit-plane median denoiser.
// Assumes: nothing beyond the standard language.
package bpm_pkg;

    // Decision taken for the centre pixel of one channel.
    typedef enum logic {
        PICK_CENTRE = 1'b0,
        PICK_MEDIAN = 1'b1
    } pick_e;

    // Width of a ones counter able to hold the value n.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bpm_plane_count.sv
// Counts the ones in one bit plane of the window (one bit taken from each pixel).
// Assumes: N >= 1; purely combinational.
module bpm_plane_count #(
    parameter int N  = 9,
    parameter int CW = 4
) (
    input  logic [N-1:0]  plane,
    output logic [CW-1:0] ones
);

    // Population count of the plane.
    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++) begin
            ones = ones + CW'(plane[i]);
        end
    end

endmodule

// File: rtl/bpm_rank_word.sv
// Builds one entry of the bitwise sorted vector: bit b is set when the ones
// count of plane b reaches the count the requested rank needs.
// Assumes: need = N - rank + 1 for rank in 1..N.
module bpm_rank_word #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic [W-1:0][CW-1:0] counts,
    input  logic [CW-1:0]        need,
    output logic [W-1:0]         word
);

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            // Plane b contributes a one when enough pixels carry it.
            assign word[b] = (counts[b] >= need);
        end
    endgenerate

endmodule

// File: rtl/bpm_channel.sv
// Two-stage filter for one colour channel. Stage 1 registers the per-plane
// ones counts, the centre value and the threshold. Stage 2 builds the needed
// sorted entries, evaluates the estimator and registers the chosen value.
// Assumes: N odd, N >= 5, thr already clamped to (N-1)/4-1.
module bpm_channel
    import bpm_pkg::*;
#(
    parameter int W   = 8,
    parameter int N   = 9,
    parameter int CTR = 4,
    parameter int TW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_s1,
    input  logic           load_s2,
    input  logic [N*W-1:0] win,
    input  logic [TW-1:0]  thr,
    output logic [W-1:0]   px
);

    localparam int CW = count_width(N);
    localparam int GW = W + 3;
    localparam int MED_NEED = (N + 1) / 2;

    logic [W-1:0][N-1:0]  plane_bits;
    logic [W-1:0][CW-1:0] cnt_d;
    logic [W-1:0][CW-1:0] cnt_q;
    logic [W-1:0]         ctr_q;
    logic [TW-1:0]        thr_q;

    genvar b, p;
    generate
        for (b = 0; b < W; b++) begin : g_plane
            for (p = 0; p < N; p++) begin : g_pix
                assign plane_bits[b][p] = win[p*W + b];
            end
            bpm_plane_count #(.N(N), .CW(CW)) u_cnt (
                .plane (plane_bits[b]),
                .ones  (cnt_d[b])
            );
        end
    endgenerate

    // Stage 1: capture counts, centre and threshold of an accepted window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ctr_q <= '0;
            thr_q <= '0;
        end else if (load_s1) begin
            cnt_q <= cnt_d;
            ctr_q <= win[CTR*W +: W];
            thr_q <= thr;
        end
    end

    logic [CW-1:0] need_min, need_max, need_med, need_lo, need_hi;
    logic [W-1:0]  t_min, t_max, t_med, t_lo, t_hi;

    // Counts each rank needs: lowest entry needs all N, highest needs 1.
    always_comb begin
        need_min = CW'(N);
        need_max = CW'(1);
        need_med = CW'(MED_NEED);
        need_lo  = CW'(N - int'(thr_q));
        need_hi  = CW'(int'(thr_q) + 1);
    end

    bpm_rank_word #(.W(W), .CW(CW)) u_min (.counts(cnt_q), .need(need_min), .word(t_min));
    bpm_rank_word #(.W(W), .CW(CW)) u_max (.counts(cnt_q), .need(need_max), .word(t_max));
    bpm_rank_word #(.W(W), .CW(CW)) u_med (.counts(cnt_q), .need(need_med), .word(t_med));
    bpm_rank_word #(.W(W), .CW(CW)) u_lo  (.counts(cnt_q), .need(need_lo),  .word(t_lo));
    bpm_rank_word #(.W(W), .CW(CW)) u_hi  (.counts(cnt_q), .need(need_hi),  .word(t_hi));

    logic signed [GW-1:0] s_x, mn_x, mx_x, lo_x, hi_x, est;
    pick_e pick;

    // Estimator and replace decision in widened signed arithmetic.
    always_comb begin
        s_x  = signed'({3'b000, ctr_q});
        mn_x = signed'({3'b000, t_min});
        mx_x = signed'({3'b000, t_max});
        lo_x = signed'({3'b000, t_lo});
        hi_x = signed'({3'b000, t_hi});
        est  = s_x + s_x + s_x - mn_x - mx_x;
        pick = ((est >= hi_x) || (est <= lo_x)) ? PICK_MEDIAN : PICK_CENTRE;
    end

    // Stage 2: register the chosen value; hold it when no window advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px <= '0;
        end else if (load_s2) begin
            px <= (pick == PICK_MEDIAN) ? t_med : ctr_q;
        end
    end

endmodule

// File: rtl/bitplane_median_denoiser.sv
// Top level: clamps the threshold, runs one channel filter per colour
// channel and carries the valid flag through the two pipeline stages.
// Assumes: N odd and >= 5, CTR < N, TW wide enough for the clamp value.
module bitplane_median_denoiser #(
    parameter int W   = 8,
    parameter int N   = 9,
    parameter int CH  = 3,
    parameter int CTR = 4,
    parameter int TW  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [N*CH*W-1:0] in_win,
    input  logic [TW-1:0]   in_thresh,
    output logic            out_valid,
    output logic [CH*W-1:0] out_px
);

    localparam int TMAX = (N - 1) / 4 - 1;

    logic [TW-1:0] thr_eff;
    logic          v1;

    // Limit the threshold to the largest usable rank offset.
    always_comb begin
        thr_eff = (int'(in_thresh) > TMAX) ? TW'(TMAX) : in_thresh;
    end

    // Valid pipeline matching the two data stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1        <= in_valid;
            out_valid <= v1;
        end
    end

    genvar c, p;
    generate
        for (c = 0; c < CH; c++) begin : g_ch
            logic [N*W-1:0] ch_win;
            for (p = 0; p < N; p++) begin : g_pix
                assign ch_win[p*W +: W] = in_win[(p*CH + c)*W +: W];
            end
            bpm_channel #(.W(W), .N(N), .CTR(CTR), .TW(TW)) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .load_s1 (in_valid),
                .load_s2 (v1),
                .win     (ch_win),
                .thr     (thr_eff),
                .px      (out_px[c*W +: W])
            );
        end
    endgenerate

endmodule

// File: rtl/bpm_checker.sv
// Property checker for the denoiser, bound to every instance of the top.
// Assumes: reset is held low across the first clock edges.
module bpm_checker #(
    parameter int W   = 8,
    parameter int N   = 9,
    parameter int CH  = 3,
    parameter int CTR = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [N*CH*W-1:0] in_win,
    input logic            out_valid,
    input logic [CH*W-1:0] out_px
);

    logic [W-1:0] and_w [CH];
    logic [W-1:0] or_w  [CH];
    logic         uni   [CH];

    // Per-channel bitwise AND / OR of the window and a uniformity flag.
    always_comb begin
        for (int c = 0; c < CH; c++) begin
            and_w[c] = '1;
            or_w[c]  = '0;
            uni[c]   = 1'b1;
            for (int p = 0; p < N; p++) begin
                and_w[c] = and_w[c] & in_win[(p*CH + c)*W +: W];
                or_w[c]  = or_w[c]  | in_win[(p*CH + c)*W +: W];
                if (in_win[(p*CH + c)*W +: W] != in_win[(CTR*CH + c)*W +: W]) begin
                    uni[c] = 1'b0;
                end
            end
        end
    end

    assert_valid_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    assert_idle_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_px));

    genvar c;
    generate
        for (c = 0; c < CH; c++) begin : g_chk
            assert_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |->
                    (((out_px[c*W +: W] & ~$past(or_w[c], 2)) == '0) &&
                     ((~out_px[c*W +: W] & $past(and_w[c], 2)) == '0)));

            assert_uniform_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(uni[c], 2)) |->
                    (out_px[c*W +: W] == $past(in_win[(CTR*CH + c)*W +: W], 2)));
        end
    endgenerate

endmodule

bind bitplane_median_denoiser bpm_checker #(.W(W), .N(N), .CH(CH), .CTR(CTR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_win    (in_win),
    .out_valid (out_valid),
    .out_px    (out_px)
);

// File: tb/bitplane_median_denoiser_tb.sv
`timescale 1ns/1ps
module bitplane_median_denoiser_tb;

    localparam int W    = 8;
    localparam int N    = 9;
    localparam int CH   = 3;
    localparam int CTR  = 4;
    localparam int TW   = 2;
    localparam int TMAX = (N - 1) / 4 - 1;
    localparam int PMAX = (1 << W) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [N*CH*W-1:0] in_win = '0;
    logic [TW-1:0]   in_thresh = '0;
    logic            out_valid;
    logic [CH*W-1:0] out_px;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int    pipe_v   [2];
    int    pipe_px  [2][CH];
    string pipe_tag [2][CH];
    int    held     [CH];
    int    pix      [N][CH];

    always #2.5 clk = ~clk;

    bitplane_median_denoiser #(.W(W), .N(N), .CH(CH), .CTR(CTR), .TW(TW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_win    (in_win),
        .in_thresh (in_thresh),
        .out_valid (out_valid),
        .out_px    (out_px)
    );

    // Reference: stack the ones of each bit column at the top ranks, then apply the rule.
    function automatic int ref_px(input int w[N], input int t, output bit rep);
        int col [N+1];
        int srt [N+1];
        int te, g, ones;
        te = (t > TMAX) ? TMAX : t;
        for (int i = 1; i <= N; i++) srt[i] = 0;
        for (int b = 0; b < W; b++) begin
            ones = 0;
            for (int p = 0; p < N; p++) ones += (w[p] >> b) & 1;
            for (int i = 1; i <= N; i++) col[i] = (i > N - ones) ? 1 : 0;
            for (int i = 1; i <= N; i++) srt[i] |= col[i] << b;
        end
        g = 3 * w[CTR] - srt[1] - srt[N];
        rep = (g >= srt[N - te]) || (g <= srt[1 + te]);
        return rep ? srt[(N + 1) / 2] : w[CTR];
    endfunction

    task automatic compare_now();
        checks++;
        if (int'(out_valid) != pipe_v[1]) begin
            errors++;
            $display("FAIL R1 out_valid actual %0d expected %0d", out_valid, pipe_v[1]);
        end
        for (int c = 0; c < CH; c++) begin
            checks++;
            if (int'(out_px[c*W +: W]) != pipe_px[1][c]) begin
                errors++;
                $display("FAIL %s ch%0d out_px actual %0d expected %0d",
                         pipe_tag[1][c], c, out_px[c*W +: W], pipe_px[1][c]);
            end
        end
    endtask

    // One cycle: check outputs, advance the model, drive the next window.
    task automatic step(input bit v, input int t, input string tag);
        int  w [N];
        bit  rep;
        @(negedge clk);
        compare_now();
        pipe_v[1] = pipe_v[0];
        for (int c = 0; c < CH; c++) begin
            pipe_px[1][c]  = pipe_px[0][c];
            pipe_tag[1][c] = pipe_tag[0][c];
        end
        in_valid  = v;
        in_thresh = TW'(t);
        for (int p = 0; p < N; p++)
            for (int c = 0; c < CH; c++)
                in_win[(p*CH + c)*W +: W] = W'(pix[p][c]);
        pipe_v[0] = v;
        for (int c = 0; c < CH; c++) begin
            if (v) begin
                for (int p = 0; p < N; p++) w[p] = pix[p][c];
                held[c] = ref_px(w, t, rep);
                pipe_tag[0][c] = {tag, rep ? " R4" : " R5"};
            end else begin
                pipe_tag[0][c] = {tag, " R9"};
            end
            pipe_px[0][c] = held[c];
        end
    endtask

    task automatic fill(input int val);
        for (int p = 0; p < N; p++)
            for (int c = 0; c < CH; c++) pix[p][c] = val;
    endtask

    function automatic int clampp(input int v);
        return (v < 0) ? 0 : ((v > PMAX) ? PMAX : v);
    endfunction

    initial begin
        void'($urandom(7));
        for (int i = 0; i < 2; i++) begin
            pipe_v[i] = 0;
            for (int c = 0; c < CH; c++) begin
                pipe_px[i][c] = 0;
                pipe_tag[i][c] = "R7";
            end
        end
        for (int c = 0; c < CH; c++) held[c] = 0;
        fill(0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R7: reset clears the outputs
        checks++;
        if (out_valid !== 1'b0 || out_px !== '0) begin
            errors++;
            $display("FAIL R7 reset outputs actual %0d/%0h expected 0/0", out_valid, out_px);
        end
        rst_n = 1'b1;

        // R2: uniform window
        fill(100);
        step(1, 0, "R2");
        // R4: salt impulse at the centre
        fill(100); for (int c = 0; c < CH; c++) pix[CTR][c] = PMAX;
        step(1, 0, "R4");
        // R4: pepper impulse at the centre
        fill(90); for (int c = 0; c < CH; c++) pix[CTR][c] = 0;
        step(1, 0, "R4");
        // R3: smooth gradient, estimator decides keep or replace
        for (int p = 0; p < N; p++) for (int c = 0; c < CH; c++) pix[p][c] = 40 + 3 * p + c;
        step(1, 0, "R3");
        step(1, 1, "R3");
        // R8: channels with unrelated content
        for (int p = 0; p < N; p++) begin
            pix[p][0] = 10 + p; pix[p][1] = 200 - 7 * p; pix[p][2] = (p == CTR) ? PMAX : 128;
        end
        step(1, 0, "R8");
        // R9: idle cycles hold the last output
        step(0, 0, "R9");
        step(0, 0, "R9");
        step(0, 0, "R9");
        // R6: clamped threshold against in-range threshold on the same window
        for (int p = 0; p < N; p++) for (int c = 0; c < CH; c++) pix[p][c] = 60 + 11 * ((p * 5 + c) % N);
        step(1, 1, "R6");
        step(1, 3, "R6");
        step(1, 2, "R6");

        // Random windows with injected impulses
        for (int k = 0; k < 400; k++) begin
            for (int c = 0; c < CH; c++) begin
                int base;
                base = $urandom_range(PMAX);
                for (int p = 0; p < N; p++) begin
                    pix[p][c] = clampp(base + $urandom_range(40) - 20);
                    if ($urandom_range(9) < 3) pix[p][c] = $urandom_range(1) ? PMAX : 0;
                end
            end
            step($urandom_range(9) < 8, $urandom_range(3), "R2");
        end
        step(0, 0, "R1");
        step(0, 0, "R1");
        step(0, 0, "R1");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule